// File: doc/BRIEF.md
# Shadowed Measurement Output Register Bank

This block is the register file that a host sees at the output of a three-axis measurement front end. One valid pulse delivers a whole measurement: two 13-bit signed axis values, one 15-bit signed axis value and a 14-bit unsigned resistance word. The block keeps them as byte-wide read registers, together with a status byte that holds an overrun flag and a control byte that enables that flag.

The host side is a plain byte read/write port. A transaction-active level frames each host access sequence, and a one-cycle end pulse marks its close. That pulse stands in for whatever the serial front end uses to end a transfer. While the host is in the middle of reading measurement bytes, the visible values stay frozen. A measurement that arrives in that window waits in a shadow copy and is committed when the transaction closes. A data-ready bit tells the host that unread data is present. When the overrun function is enabled, the overrun flag records that a new measurement replaced data that was never read.

Top module: `sense_regbank`

## Requirements
- R1: After reset, every readable byte returns 0x00: all measurement bytes, the status byte (0x4A) and the control byte (0x4D). Data-ready is 0.
- R2: The first axis reads as {value[4:0],3'b000} at 0x42 and value[12:5] at 0x43. The second axis uses the same layout at 0x44/0x45.
- R3: The third axis reads as {value[6:0],1'b0} at 0x46 and value[14:7] at 0x47. The resistance word reads as {value[5:0],1'b0,data_ready} at 0x48 and value[13:6] at 0x49.
- R4: The visible values of a measurement all change on the same clock edge. While the current transaction has read any byte from 0x42 to 0x49, the visible values do not change.
- R5: A measurement that arrives while the visible values are frozen is held in a shadow. It becomes visible on the edge at which the transaction end pulse is sampled.
- R6: Data-ready goes to 1 when the visible values are updated. It goes to 0 when a transaction that read a byte from 0x42 to 0x49 ends. At that end, the clear is applied first and a commit applied afterwards, so a committed shadow leaves data-ready at 1.
- R7: When control bit 7 is 1, an update that finds data-ready at 1 sets the overrun flag (status 0x4A bit 7). The data-ready value used here is the one after any end-of-transaction clear in the same cycle. When control bit 7 is 0, the flag is never set.
- R8: A read of 0x4A returns the flag as it was before the read and then clears it.
- R9: When several measurements arrive during one frozen transaction, only the newest one becomes visible.
- R10: Address 0x4D is the only writable location, and all 8 of its bits are read back. Writes to any other address have no effect.
- R11: When a read of 0x4A and an overrun-setting update fall in the same cycle, the flag ends up at 1.
- R12: Reads from addresses that hold no register return 0x00.
- R13: When a fresh measurement arrives in the same cycle as the end pulse, the fresh measurement becomes visible and any held shadow is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_valid | input | 1 | One-cycle strobe: a complete measurement is present |
| pkt_ax0 | input | 13 | First axis, two's complement |
| pkt_ax1 | input | 13 | Second axis, two's complement |
| pkt_ax2 | input | 15 | Third axis, two's complement |
| pkt_res | input | 14 | Resistance word, unsigned |
| host_active | input | 1 | High while a host transaction is in progress |
| host_end | input | 1 | One-cycle pulse closing the transaction |
| host_rd | input | 1 | Read strobe for host_addr |
| host_wr | input | 1 | Write strobe for host_addr |
| host_addr | input | 8 | Byte address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational, valid while host_rd is high |

## Verification
Two events can fall in the same cycle. One is the read of the status byte, which clears the overrun flag. The other is an update that sets that flag. The bench provokes this by enabling overrun and leaving data-ready set. It then issues a status read in the same cycle as a measurement pulse, expects the old flag value on that read and a set flag on the next status read. A second collision places a fresh measurement on the end pulse while a shadow is pending. It is judged by reading back the whole set of data bytes and checking that only the fresh values appear, with data-ready set.

// File: rtl/sense_regbank_pkg.sv
// sense_regbank_pkg
// Shared widths, register addresses and the measurement record type for
// the shadowed measurement register bank.
package sense_regbank_pkg;

    localparam int AXW  = 13;   // width of the first and second axis
    localparam int ZW   = 15;   // width of the third axis
    localparam int RW   = 14;   // width of the resistance word
    localparam int BW   = 8;    // host byte width

    localparam int AX_LO = AXW - BW;  // low-part bits of an axis
    localparam int Z_LO  = ZW - BW;
    localparam int R_LO  = RW - BW;

    localparam logic [BW-1:0] ADDR_AX0_LO = 8'h42;
    localparam logic [BW-1:0] ADDR_AX0_HI = 8'h43;
    localparam logic [BW-1:0] ADDR_AX1_LO = 8'h44;
    localparam logic [BW-1:0] ADDR_AX1_HI = 8'h45;
    localparam logic [BW-1:0] ADDR_AX2_LO = 8'h46;
    localparam logic [BW-1:0] ADDR_AX2_HI = 8'h47;
    localparam logic [BW-1:0] ADDR_RES_LO = 8'h48;
    localparam logic [BW-1:0] ADDR_RES_HI = 8'h49;
    localparam logic [BW-1:0] ADDR_STAT   = 8'h4A;
    localparam logic [BW-1:0] ADDR_CTRL   = 8'h4D;

    localparam int OVR_EN_BIT = 7;   // control byte: overrun enable
    localparam int OVR_BIT    = 7;   // status byte: overrun flag

    typedef struct packed {
        logic [AXW-1:0] ax0;
        logic [AXW-1:0] ax1;
        logic [ZW-1:0]  ax2;
        logic [RW-1:0]  res;
    } meas_t;

    // True for any byte of the measurement window.
    function automatic logic is_meas_addr(input logic [BW-1:0] a);
        return (a >= ADDR_AX0_LO) && (a <= ADDR_RES_HI);
    endfunction

endpackage

// File: rtl/sense_txn_track.sv
// sense_txn_track
// Follows one host transaction and reports whether it has read any
// measurement byte. Assumes host_end is a single-cycle pulse that is not
// raised in the same cycle as a read strobe.
module sense_txn_track
    import sense_regbank_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_active,
    input  logic          host_end,
    input  logic          host_rd,
    input  logic [BW-1:0] host_addr,
    output logic          txn_read,
    output logic          blocked
);

    logic seen_q;
    logic rd_meas_now;

    // Detect a measurement-byte read in the current cycle.
    always_comb begin
        rd_meas_now = host_rd && host_active && is_meas_addr(host_addr);
        txn_read    = seen_q || rd_meas_now;
        blocked     = txn_read && !host_end;
    end

    // Remember a measurement-byte read until the transaction closes.
    always_ff @(posedge clk) begin
        if (!rst_n)              seen_q <= 1'b0;
        else if (host_end)       seen_q <= 1'b0;
        else if (rd_meas_now)    seen_q <= 1'b1;
    end

    assert_seen_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        host_end |=> !seen_q);

    assert_seen_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !host_end) |=> seen_q);

endmodule

// File: rtl/sense_meas_store.sv
// sense_meas_store
// Holds the visible measurement and a single-entry shadow. A measurement
// goes straight to the visible copy unless blocked. A blocked one
// overwrites the shadow and is committed on the end pulse. A fresh
// measurement on the end pulse wins over the shadow.
module sense_meas_store
    import sense_regbank_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pkt_valid,
    input  meas_t pkt_in,
    input  logic  blocked,
    input  logic  host_end,
    output meas_t vis,
    output logic  upd
);

    meas_t vis_q, shadow_q;
    logic  pend_q;
    logic  direct, commit;

    // Decide whether the visible copy changes this cycle.
    always_comb begin
        direct = pkt_valid && !blocked;
        commit = host_end && pend_q;
        upd    = direct || commit;
        vis    = vis_q;
    end

    // Update every visible field together.
    always_ff @(posedge clk) begin
        if (!rst_n)       vis_q <= '0;
        else if (direct)  vis_q <= pkt_in;
        else if (commit)  vis_q <= shadow_q;
    end

    // Keep the newest blocked measurement and its pending mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            pend_q   <= 1'b0;
        end else if (pkt_valid && blocked) begin
            shadow_q <= pkt_in;
            pend_q   <= 1'b1;
        end else if (host_end) begin
            pend_q   <= 1'b0;
        end
    end

    assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |=> $stable(vis_q));

    assert_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_end && pend_q && !pkt_valid) |=> (vis_q == $past(shadow_q)));

    assert_newest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && blocked) |=> (pend_q && shadow_q == $past(pkt_in)));

    assert_fresh_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (host_end && pkt_valid) |=> (vis_q == $past(pkt_in) && !pend_q));

endmodule

// File: rtl/sense_flag_unit.sv
// sense_flag_unit
// Holds data-ready, the overrun flag and the control byte. At the close
// of a transaction that read measurement data, data-ready is cleared
// before any update is applied, so a commit in that cycle sets it again.
module sense_flag_unit
    import sense_regbank_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic          txn_read,
    input  logic          host_end,
    input  logic          host_rd,
    input  logic          host_wr,
    input  logic [BW-1:0] host_addr,
    input  logic [BW-1:0] host_wdata,
    output logic          drdy,
    output logic          ovr,
    output logic [BW-1:0] ctrl
);

    logic          drdy_q, ovr_q;
    logic [BW-1:0] ctrl_q;
    logic          rd_clear, drdy_mid, ovr_set, stat_rd, ctrl_wr;

    // Order the end-of-read clear ahead of the update.
    always_comb begin
        rd_clear = host_end && txn_read;
        drdy_mid = rd_clear ? 1'b0 : drdy_q;
        ovr_set  = upd && ctrl_q[OVR_EN_BIT] && drdy_mid;
        stat_rd  = host_rd && (host_addr == ADDR_STAT);
        ctrl_wr  = host_wr && (host_addr == ADDR_CTRL);
        drdy     = drdy_q;
        ovr      = ovr_q;
        ctrl     = ctrl_q;
    end

    // Data-ready: set by update, cleared by a completed data read.
    always_ff @(posedge clk) begin
        if (!rst_n) drdy_q <= 1'b0;
        else        drdy_q <= upd ? 1'b1 : drdy_mid;
    end

    // Overrun flag: setting beats the status-read clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovr_q <= 1'b0;
        else if (ovr_set) ovr_q <= 1'b1;
        else if (stat_rd) ovr_q <= 1'b0;
    end

    // Control byte: the only writable register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= host_wdata;
    end

    assert_drdy_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> drdy_q);

    assert_drdy_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_end && txn_read && !upd) |=> !drdy_q);

    assert_ovr_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && ctrl_q[OVR_EN_BIT] && drdy_q && !host_end) |=> ovr_q);

    assert_ovr_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[OVR_EN_BIT] && !ovr_q) |=> !ovr_q);

    assert_ovr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == ADDR_STAT && !upd) |=> !ovr_q);

    assert_ctrl_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_addr == ADDR_CTRL) |=> $stable(ctrl_q));

endmodule

// File: rtl/sense_reg_read.sv
// sense_reg_read
// Combinational read multiplexer. The low part of each value sits in the
// upper bits of its low byte, padded with zeros below it. Bit 0 of the
// resistance low byte carries data-ready. Unmapped addresses read 0.
module sense_reg_read
    import sense_regbank_pkg::*;
(
    input  meas_t         vis,
    input  logic          drdy,
    input  logic          ovr,
    input  logic [BW-1:0] ctrl,
    input  logic          host_rd,
    input  logic [BW-1:0] host_addr,
    output logic [BW-1:0] rdata
);

    logic [BW-1:0] ax0_lo, ax1_lo, ax2_lo, res_lo, stat_b;

    // Form the padded low bytes and the status byte.
    always_comb begin
        ax0_lo = {vis.ax0[AX_LO-1:0], {(BW-AX_LO){1'b0}}};
        ax1_lo = {vis.ax1[AX_LO-1:0], {(BW-AX_LO){1'b0}}};
        ax2_lo = {vis.ax2[Z_LO-1:0],  {(BW-Z_LO){1'b0}}};
        res_lo = {vis.res[R_LO-1:0],  {(BW-R_LO-1){1'b0}}, drdy};
        stat_b = '0;
        stat_b[OVR_BIT] = ovr;
    end

    // Select the addressed byte.
    always_comb begin
        rdata = '0;
        if (host_rd) begin
            unique case (host_addr)
                ADDR_AX0_LO: rdata = ax0_lo;
                ADDR_AX0_HI: rdata = vis.ax0[AXW-1:AX_LO];
                ADDR_AX1_LO: rdata = ax1_lo;
                ADDR_AX1_HI: rdata = vis.ax1[AXW-1:AX_LO];
                ADDR_AX2_LO: rdata = ax2_lo;
                ADDR_AX2_HI: rdata = vis.ax2[ZW-1:Z_LO];
                ADDR_RES_LO: rdata = res_lo;
                ADDR_RES_HI: rdata = vis.res[RW-1:R_LO];
                ADDR_STAT:   rdata = stat_b;
                ADDR_CTRL:   rdata = ctrl;
                default:     rdata = '0;
            endcase
        end
    end

    // Unmapped addresses must read as zero.
    always_comb begin
        if (host_rd && !is_meas_addr(host_addr) && host_addr != ADDR_STAT
            && host_addr != ADDR_CTRL)
            assert_unmapped_zero_R12: assert (rdata == '0);
    end

endmodule

// File: rtl/sense_regbank.sv
// sense_regbank
// Top of the shadowed measurement register bank. It joins the
// transaction tracker, the visible/shadow store, the flag unit and the
// read multiplexer. Assumes one host transaction at a time.
module sense_regbank
    import sense_regbank_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pkt_valid,
    input  logic [AXW-1:0] pkt_ax0,
    input  logic [AXW-1:0] pkt_ax1,
    input  logic [ZW-1:0]  pkt_ax2,
    input  logic [RW-1:0]  pkt_res,
    input  logic           host_active,
    input  logic           host_end,
    input  logic           host_rd,
    input  logic           host_wr,
    input  logic [BW-1:0]  host_addr,
    input  logic [BW-1:0]  host_wdata,
    output logic [BW-1:0]  host_rdata
);

    meas_t         pkt_in, vis;
    logic          txn_read, blocked, upd, drdy, ovr;
    logic [BW-1:0] ctrl;

    // Gather the incoming fields into one record.
    always_comb pkt_in = '{ax0: pkt_ax0, ax1: pkt_ax1, ax2: pkt_ax2, res: pkt_res};

    sense_txn_track u_txn (
        .clk(clk), .rst_n(rst_n), .host_active(host_active),
        .host_end(host_end), .host_rd(host_rd), .host_addr(host_addr),
        .txn_read(txn_read), .blocked(blocked)
    );

    sense_meas_store u_store (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_in(pkt_in),
        .blocked(blocked), .host_end(host_end), .vis(vis), .upd(upd)
    );

    sense_flag_unit u_flags (
        .clk(clk), .rst_n(rst_n), .upd(upd), .txn_read(txn_read),
        .host_end(host_end), .host_rd(host_rd), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .drdy(drdy), .ovr(ovr), .ctrl(ctrl)
    );

    sense_reg_read u_read (
        .vis(vis), .drdy(drdy), .ovr(ovr), .ctrl(ctrl),
        .host_rd(host_rd), .host_addr(host_addr), .rdata(host_rdata)
    );

endmodule

// File: tb/tb_sense_regbank.sv
// Scoreboard bench: read tasks queue the expected byte, a monitor at the
// falling edge pops and compares it against host_rdata.
module tb_sense_regbank;
    import sense_regbank_pkg::*;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           pkt_valid = 1'b0;
    logic [AXW-1:0] pkt_ax0 = '0, pkt_ax1 = '0;
    logic [ZW-1:0]  pkt_ax2 = '0;
    logic [RW-1:0]  pkt_res = '0;
    logic           host_active = 1'b0, host_end = 1'b0;
    logic           host_rd = 1'b0, host_wr = 1'b0;
    logic [BW-1:0]  host_addr = '0, host_wdata = '0;
    logic [BW-1:0]  host_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] exp;
        logic [7:0] addr;
        string      tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    sense_regbank dut (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid),
        .pkt_ax0(pkt_ax0), .pkt_ax1(pkt_ax1), .pkt_ax2(pkt_ax2),
        .pkt_res(pkt_res), .host_active(host_active), .host_end(host_end),
        .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    // Expected byte image of a measurement, from the packing requirements.
    function automatic logic [7:0] enc(meas_t p, logic [7:0] a, logic dr);
        case (a)
            8'h42: return {p.ax0[4:0], 3'b000};
            8'h43: return p.ax0[12:5];
            8'h44: return {p.ax1[4:0], 3'b000};
            8'h45: return p.ax1[12:5];
            8'h46: return {p.ax2[6:0], 1'b0};
            8'h47: return p.ax2[14:7];
            8'h48: return {p.res[5:0], 1'b0, dr};
            8'h49: return p.res[13:6];
            default: return 8'h00;
        endcase
    endfunction

    function automatic meas_t mk(logic [12:0] a, logic [12:0] b,
                                 logic [14:0] c, logic [13:0] r);
        meas_t m;
        m.ax0 = a; m.ax1 = b; m.ax2 = c; m.res = r;
        return m;
    endfunction

    // Monitor: compare each read against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && host_rd) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL unexpected read addr=%02h actual=%02h expected=none", host_addr, host_rdata);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (host_rdata !== it.exp || host_addr !== it.addr) begin
                    fails++;
                    $display("FAIL %s addr=%02h actual=%02h expected=%02h",
                             it.tag, host_addr, host_rdata, it.exp);
                end
            end
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
        host_rd = 1'b0; host_wr = 1'b0; host_end = 1'b0; pkt_valid = 1'b0;
    endtask

    task automatic push(logic [7:0] a, logic [7:0] e, string tag);
        item_t it;
        it.exp = e; it.addr = a; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic rd(logic [7:0] a, logic [7:0] e, string tag);
        host_active = 1'b1; host_rd = 1'b1; host_addr = a;
        push(a, e, tag);
        cyc();
    endtask

    task automatic load(meas_t p);
        pkt_valid = 1'b1;
        pkt_ax0 = p.ax0; pkt_ax1 = p.ax1; pkt_ax2 = p.ax2; pkt_res = p.res;
    endtask

    task automatic send(meas_t p);
        load(p);
        cyc();
    endtask

    task automatic fin();
        host_active = 1'b0; host_end = 1'b1;
        cyc();
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        host_active = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
        cyc();
        fin();
    endtask

    task automatic burst(meas_t p, logic dr, string tag);
        for (int a = 8'h42; a <= 8'h49; a++)
            rd(8'(a), enc(p, 8'(a), dr), tag);
    endtask

    meas_t p1, p2, p3, p4, p5, p6, p7, p8, p9;

    initial begin
        p1 = mk(13'h1FFD, 13'h0A55, 15'h4321, 14'h2ABC);
        p2 = mk(13'h0111, 13'h0222, 15'h0333, 14'h0444);
        p3 = mk(13'h1357, 13'h02468 & 13'h1FFF, 15'h7FFF, 14'h3FFF);
        p4 = mk(13'h0001, 13'h0002, 15'h0003, 14'h0004);
        p5 = mk(13'h1000, 13'h0FFF, 15'h4000, 14'h2000);
        p6 = mk(13'h0ABC, 13'h1DEF, 15'h1234, 14'h1555);
        p7 = mk(13'h1E1E, 13'h0C3C, 15'h5A5A, 14'h0F0F);
        p8 = mk(13'h1111, 13'h1111, 15'h1111, 14'h1111);
        p9 = mk(13'h0F81, 13'h107E, 15'h6C93, 14'h3A5C);

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset contents
        for (int a = 8'h42; a <= 8'h49; a++) rd(8'(a), 8'h00, "R1 reset data");
        rd(8'h4A, 8'h00, "R1 reset status");
        rd(8'h4D, 8'h00, "R1 reset ctrl");
        fin();

        // R10: control byte write and readback
        wr(8'h4D, 8'h80);
        rd(8'h4D, 8'h80, "R10 ctrl readback");
        fin();

        // R2 R3 R4: full burst of a first measurement, data-ready 1
        send(p1);
        burst(p1, 1'b1, "R2/R3 packing");
        rd(8'h4A, 8'h00, "R7 no overrun on first update");
        fin();

        // R6 clear; R4 frozen; R9 newest; R5 commit
        rd(8'h48, enc(p1, 8'h48, 1'b0), "R6 drdy cleared after read");
        send(p2);
        rd(8'h43, enc(p1, 8'h43, 1'b0), "R4 frozen during read");
        send(p3);
        rd(8'h49, enc(p1, 8'h49, 1'b0), "R4 frozen after two arrivals");
        fin();
        rd(8'h4A, 8'h00, "R7 commit after clear gives no overrun");
        burst(p3, 1'b1, "R5 R9 newest shadow committed, R6 drdy set");
        fin();

        // R7 overrun set, R8 clear on read
        send(p4);
        send(p5);
        rd(8'h4A, 8'h80, "R7 overrun set");
        rd(8'h4A, 8'h00, "R8 overrun cleared by read");
        fin();

        // R11: status read in the same cycle as an overrun-setting update
        host_active = 1'b1; host_rd = 1'b1; host_addr = 8'h4A;
        push(8'h4A, 8'h00, "R11 old value during collision");
        load(p6);
        cyc();
        rd(8'h4A, 8'h80, "R11 set wins over clear");
        rd(8'h4A, 8'h00, "R8 cleared after collision");
        fin();

        // R7 disabled
        wr(8'h4D, 8'h00);
        send(p7);
        rd(8'h4A, 8'h00, "R7 no overrun when disabled");
        rd(8'h4D, 8'h00, "R10 ctrl cleared");
        fin();

        // R10 ignored writes, R12 unmapped reads
        wr(8'h42, 8'hFF);
        wr(8'h4A, 8'hFF);
        rd(8'h50, 8'h00, "R12 unmapped 0x50");
        rd(8'h4B, 8'h00, "R12 unmapped 0x4B");
        rd(8'h41, 8'h00, "R12 unmapped 0x41");
        rd(8'h4A, 8'h00, "R10 status not writable");
        rd(8'h42, enc(p7, 8'h42, 1'b1), "R10 data not writable");
        rd(8'h48, enc(p7, 8'h48, 1'b1), "R6 drdy still set");
        fin();

        // R13: fresh measurement on the end pulse beats the shadow
        rd(8'h42, enc(p7, 8'h42, 1'b0), "R4 before end collision");
        send(p8);
        host_active = 1'b0; host_end = 1'b1;
        load(p9);
        cyc();
        burst(p9, 1'b1, "R13 fresh wins at end");
        fin();

        repeat (3) @(posedge clk);
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL scoreboard left=%0d expected=0", sb.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule